// File: doc/BRIEF.md
# AES-128 Round-Key Pipeline

This block turns a 128-bit AES cipher key into the round keys that an unrolled, round-per-stage encryption datapath needs. It does not precompute a key table. Each pipeline stage keeps the round key of the block it currently holds and derives the next round key from it. The key therefore moves through the stages in lockstep with its data block. A different key may arrive with every plaintext, one per clock, and no block is ever paired with a round key that belongs to a neighbouring block.

The initial round key is the cipher key itself, and it is passed straight through for the first key addition. Stage r registers the previous round key and shows round key r on its output. The matching data round uses that key in the same cycle. A valid bit travels with each key, so the data pipeline can tell a live stage from a bubble.

Top module: `aes_key_pipe`

## Requirements
- R1: `rk0` equals `cipher_key` in the same cycle, with no register in between.
- R2: Suppose a key is accepted, meaning `key_valid` is high at a rising edge. Exactly r edges later, stage r (1 to 10) presents round key K_r of that key on `rk_bus[128*r-1 -: 128]`. In each 128-bit key, word w0 sits in bits 127:96 and w3 sits in bits 31:0.
- R3: `rk_valid` bit r-1 is high in exactly those cycles in which stage r holds an accepted key.
- R4: A new key can be accepted on every clock. When consecutive blocks carry different keys, each key's round keys stay with that block through all ten stages.
- R5: A stage derives the next key as follows. First word: previous w0 XOR SubWord(RotWord(previous w3)) XOR Rcon. Each later word: previous word at the same position XOR the new word before it. RotWord rotates a word left by one byte, and SubWord applies the AES S-box to each byte. Rcon for round r is the byte in the sequence 01,02,04,08,10,20,40,80,1B,36, placed in bits 31:24 of the word. For key 2b7e151628aed2a6abf7158809cf4f3c, K10 is d014f9a8c9ee2589e13f0cc8b6630ca6.
- R6: A stage that receives no valid key keeps its key register unchanged, so its round-key output does not move during bubbles.
- R7: A synchronous active-low reset clears every valid bit and every stage key register. Stage r then shows one expansion step of an all-zero key with round constant r.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| key_valid | input | 1 | A cipher key is presented this cycle |
| cipher_key | input | 128 | Cipher key, w0 in bits 127:96 |
| rk0 | output | 128 | Round key 0 for the initial key addition |
| rk_valid | output | 10 | Bit r-1: stage r holds a live key |
| rk_bus | output | 1280 | Round key r in bits 128*r-1 down to 128*(r-1) |

## Verification
Two things can happen to a stage in the same cycle. It can hand its round key to the next stage while capturing a different key from the stage before it. It can also hold a stale key while its neighbours move on. The bench provokes the first case with a burst of distinct keys on consecutive cycles and the second with gapped and alternating valid patterns. It also asserts reset while keys are in flight. A cycle-level reference model of every stage, together with a scoreboard of expected final round keys, judges each stage's output and valid bit in every cycle.

// File: rtl/aes_ks_pkg.sv
// Shared types and GF(2^8) helpers for the AES-128 round-key pipeline.
// Assumes: bytes are in big-endian order within words and keys.
package aes_ks_pkg;

    localparam int BYTE_W  = 8;
    localparam int WORD_W  = 32;
    localparam int KEY_W   = 128;
    localparam int MAX_RND = 10;

    typedef logic [BYTE_W-1:0] byte_t;
    typedef logic [WORD_W-1:0] word_t;
    typedef logic [KEY_W-1:0]  key_t;

    // Multiply by x modulo the AES polynomial.
    function automatic byte_t gf_xtime(byte_t a);
        return {a[6:0], 1'b0} ^ (a[7] ? 8'h1B : 8'h00);
    endfunction

    // General GF(2^8) product by shift-and-add.
    function automatic byte_t gf_mul(byte_t a, byte_t b);
        byte_t acc;
        byte_t sh;
        acc = '0;
        sh  = a;
        for (int i = 0; i < BYTE_W; i++) begin
            if (b[i]) acc = acc ^ sh;
            sh = gf_xtime(sh);
        end
        return acc;
    endfunction

    // Multiplicative inverse as a^254; zero maps to zero.
    function automatic byte_t gf_inv(byte_t a);
        byte_t pw;
        byte_t acc;
        pw  = a;
        acc = 8'h01;
        for (int i = 1; i < BYTE_W; i++) begin
            pw  = gf_mul(pw, pw);
            acc = gf_mul(acc, pw);
        end
        return acc;
    endfunction

    // Affine output transform of the S-box.
    function automatic byte_t sbox_affine(byte_t v);
        return v ^ {v[6:0], v[7]} ^ {v[5:0], v[7:6]} ^
               {v[4:0], v[7:5]} ^ {v[3:0], v[7:4]} ^ 8'h63;
    endfunction

    // Round constant for round r (1-based), built by repeated doubling.
    function automatic byte_t round_const(int r);
        byte_t c;
        c = 8'h01;
        for (int i = 1; i < MAX_RND; i++) begin
            if (i < r) c = gf_xtime(c);
        end
        return c;
    endfunction

endpackage

// File: rtl/aes_ks_sbox.sv
// One AES forward S-box, computed from inversion and affine map.
// Assumes: purely combinational; the caller provides the timing budget.
module aes_ks_sbox
    import aes_ks_pkg::*;
(
    input  byte_t din,
    output byte_t dout
);

    // Substitute one byte.
    always_comb begin
        dout = sbox_affine(gf_inv(din));
    end

endmodule

// File: rtl/aes_ks_step.sv
// One AES-128 key-schedule step: derives round key ROUND from round key ROUND-1.
// Assumes: ROUND lies in 1..10.
module aes_ks_step
    import aes_ks_pkg::*;
#(
    parameter int ROUND = 1
) (
    input  key_t prev_key,
    output key_t next_key
);

    localparam byte_t RCON = round_const(ROUND);
    localparam int    NB   = WORD_W / BYTE_W;

    word_t w0, w1, w2, w3;
    word_t rot_w;
    word_t sub_w;
    word_t n0, n1, n2, n3;

    // Split the previous key and rotate its last word by one byte.
    always_comb begin
        {w0, w1, w2, w3} = prev_key;
        rot_w = {w3[23:0], w3[31:24]};
    end

    genvar b;
    generate
        for (b = 0; b < NB; b++) begin : g_sub
            aes_ks_sbox u_sbox (
                .din  (rot_w[b*BYTE_W +: BYTE_W]),
                .dout (sub_w[b*BYTE_W +: BYTE_W])
            );
        end
    endgenerate

    // Chain the XORs that produce the four new words.
    always_comb begin
        n0 = w0 ^ sub_w ^ {RCON, 24'h000000};
        n1 = w1 ^ n0;
        n2 = w2 ^ n1;
        n3 = w3 ^ n2;
        next_key = {n0, n1, n2, n3};
    end

endmodule

// File: rtl/aes_ks_stage.sv
// One pipeline stage: registers the previous round key of its block and
// presents the round key for round ROUND derived from it.
// Assumes: the upstream key is valid only when up_valid is high.
module aes_ks_stage
    import aes_ks_pkg::*;
#(
    parameter int ROUND = 1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic up_valid,
    input  key_t up_key,
    output logic stage_valid,
    output key_t held_key,
    output key_t round_key
);

    // Capture the upstream key when valid and advance the valid bit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stage_valid <= 1'b0;
            held_key    <= '0;
        end else begin
            stage_valid <= up_valid;
            if (up_valid) held_key <= up_key;
        end
    end

    aes_ks_step #(.ROUND(ROUND)) u_step (
        .prev_key (held_key),
        .next_key (round_key)
    );

    // R6: a bubble leaves the stored key untouched.
    a_r6_hold_on_bubble: assert property (@(posedge clk) disable iff (!rst_n)
        !up_valid |=> $stable(held_key));

    // R7: reset empties the stage.
    a_r7_reset_clear: assert property (@(posedge clk)
        !rst_n |=> (!stage_valid && held_key == '0));

endmodule

// File: rtl/aes_key_pipe.sv
// AES-128 round-key pipeline: expands each cipher key one round per stage,
// in lockstep with an unrolled data pipeline.
// Assumes: NUM_STAGES is at most 10; stage r serves encryption round r.
module aes_key_pipe
    import aes_ks_pkg::*;
#(
    parameter int NUM_STAGES = 10
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        key_valid,
    input  logic [KEY_W-1:0]            cipher_key,
    output logic [KEY_W-1:0]            rk0,
    output logic [NUM_STAGES-1:0]       rk_valid,
    output logic [NUM_STAGES*KEY_W-1:0] rk_bus
);

    logic [NUM_STAGES:0] v_chain;
    key_t                k_chain [0:NUM_STAGES];
    key_t                held    [1:NUM_STAGES];

    // Feed the cipher key into the chain and out as the initial round key.
    always_comb begin
        v_chain[0] = key_valid;
        k_chain[0] = cipher_key;
        rk0        = cipher_key;
    end

    genvar g;
    generate
        for (g = 1; g <= NUM_STAGES; g++) begin : g_stage
            aes_ks_stage #(.ROUND(g)) u_stage (
                .clk         (clk),
                .rst_n       (rst_n),
                .up_valid    (v_chain[g-1]),
                .up_key      (k_chain[g-1]),
                .stage_valid (v_chain[g]),
                .held_key    (held[g]),
                .round_key   (k_chain[g])
            );

            assign rk_valid[g-1]               = v_chain[g];
            assign rk_bus[g*KEY_W-1 -: KEY_W]  = k_chain[g];

            // R3: a live key advances exactly one stage per clock.
            a_r3_valid_chain: assert property (@(posedge clk) disable iff (!rst_n)
                v_chain[g-1] |=> v_chain[g]);

            // R2: the stage captures the key its neighbour presented.
            a_r2_key_handoff: assert property (@(posedge clk) disable iff (!rst_n)
                v_chain[g-1] |=> (held[g] == $past(k_chain[g-1])));
        end
    endgenerate

endmodule

// File: tb/aes_key_pipe_tb.sv
`timescale 1ns/1ps
module aes_key_pipe_tb;

    localparam int NS = 10;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             drv_valid = 1'b0;
    logic [127:0]     drv_key = '0;
    logic [127:0]     rk0;
    logic [NS-1:0]    rk_valid;
    logic [NS*128-1:0] rk_bus;

    int n_total = 0;
    int n_fail  = 0;
    bit mon_en  = 1'b0;
    bit done    = 1'b0;

    logic [7:0]   sb [0:255];
    logic [7:0]   rc [1:10] = '{8'h01, 8'h02, 8'h04, 8'h08, 8'h10,
                                 8'h20, 8'h40, 8'h80, 8'h1B, 8'h36};
    logic         m_valid [1:NS];
    logic [127:0] m_held  [1:NS];
    logic [127:0] exp_q [$];
    string        tag_q [$];

    always #5 clk = ~clk;

    aes_key_pipe u_dut (
        .clk(clk), .rst_n(rst_n), .key_valid(drv_valid), .cipher_key(drv_key),
        .rk0(rk0), .rk_valid(rk_valid), .rk_bus(rk_bus)
    );

    function automatic logic [7:0] rl(logic [7:0] v, int n);
        return (v << n) | (v >> (8 - n));
    endfunction

    // S-box table built by walking generator 3 and its inverse.
    initial begin
        logic [7:0] p, q;
        p = 8'h01; q = 8'h01;
        do begin
            p = p ^ (p << 1) ^ ((p & 8'h80) != 0 ? 8'h1B : 8'h00);
            q = q ^ (q << 1);
            q = q ^ (q << 2);
            q = q ^ (q << 4);
            if (q[7]) q = q ^ 8'h09;
            sb[p] = q ^ rl(q, 1) ^ rl(q, 2) ^ rl(q, 3) ^ rl(q, 4) ^ 8'h63;
        end while (p != 8'h01);
        sb[0] = 8'h63;
    end

    function automatic logic [127:0] tb_step(logic [127:0] k, int r);
        logic [31:0] a, b, c, d, t;
        {a, b, c, d} = k;
        t = {sb[d[23:16]], sb[d[15:8]], sb[d[7:0]], sb[d[31:24]]} ^ {rc[r], 24'h0};
        a = a ^ t; b = b ^ a; c = c ^ b; d = d ^ c;
        return {a, b, c, d};
    endfunction

    function automatic logic [127:0] tb_expand(logic [127:0] k);
        logic [127:0] x = k;
        for (int r = 1; r <= NS; r++) x = tb_step(x, r);
        return x;
    endfunction

    task automatic chk(string req, string what, logic [127:0] act, logic [127:0] exp);
        n_total++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // Reference model of the stage registers (R2, R3, R6, R7).
    always @(posedge clk) begin
        if (!rst_n) begin
            for (int r = 1; r <= NS; r++) begin
                m_valid[r] <= 1'b0;
                m_held[r]  <= '0;
            end
        end else begin
            m_valid[1] <= drv_valid;
            if (drv_valid) m_held[1] <= drv_key;
            for (int r = 2; r <= NS; r++) begin
                m_valid[r] <= m_valid[r-1];
                if (m_valid[r-1]) m_held[r] <= tb_step(m_held[r-1], r - 1);
            end
        end
    end

    // Monitor: compares every stage and pops the final-round scoreboard.
    always @(negedge clk) begin
        if (mon_en) begin
            chk("R1", "rk0", rk0, drv_key);
            for (int r = 1; r <= NS; r++) begin
                chk("R3", $sformatf("valid stage %0d", r), 128'(rk_valid[r-1]), 128'(m_valid[r]));
                chk("R2", $sformatf("key stage %0d", r), rk_bus[r*128-1 -: 128],
                    tb_step(m_held[r], r));
            end
            if (rk_valid[NS-1]) begin
                if (exp_q.size() == 0) begin
                    chk("R4", "unexpected output", 128'h1, 128'h0);
                end else begin
                    chk(tag_q.pop_front(), "final round key", rk_bus[NS*128-1 -: 128],
                        exp_q.pop_front());
                end
            end
        end
    end

    task automatic send(logic [127:0] k, string tag);
        @(negedge clk); #1;
        drv_valid = 1'b1; drv_key = k;
        exp_q.push_back(tb_expand(k)); tag_q.push_back(tag);
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk); #1;
            drv_valid = 1'b0;
        end
    endtask

    initial begin
        repeat (3) @(posedge clk);
        mon_en = 1'b1;
        @(negedge clk);
        chk("R7", "valid after reset", 128'(rk_valid), 128'h0);
        chk("R7", "stage1 after reset", rk_bus[127:0], tb_step('0, 1));
        #1 rst_n = 1'b1;

        // R5: known expansion vector, pushed with its literal result.
        @(negedge clk); #1;
        drv_valid = 1'b1; drv_key = 128'h2b7e151628aed2a6abf7158809cf4f3c;
        exp_q.push_back(128'hd014f9a8c9ee2589e13f0cc8b6630ca6); tag_q.push_back("R5");
        idle(15);
        // R6: after a long bubble the last stage still shows the same key.
        @(negedge clk);
        chk("R6", "stage10 held", rk_bus[NS*128-1 -: 128], 128'hd014f9a8c9ee2589e13f0cc8b6630ca6);

        // R4: back-to-back distinct keys.
        for (int i = 0; i < 24; i++)
            send({32'h9E3779B9 * (i + 1), 32'h7F4A7C15 ^ i, 32'h85EBCA6B * i, 32'(i)}, "R4");
        idle(2);
        // Alternating valid pattern.
        for (int i = 0; i < 12; i++) begin
            send({4{32'hC2B2AE35 * (i + 3)}}, "R4");
            idle(1 + (i % 3));
        end
        send('0, "R5");
        send({128{1'b1}}, "R5");
        idle(14);

        // R7: reset with keys in flight.
        for (int i = 0; i < 5; i++) send({4{32'h27D4EB2F + i}}, "R4");
        @(negedge clk); #1;
        drv_valid = 1'b0; rst_n = 1'b0;
        exp_q.delete(); tag_q.delete();
        @(negedge clk);
        chk("R7", "valid after mid reset", 128'(rk_valid), 128'h0);
        #1 rst_n = 1'b1;
        send(128'h000102030405060708090a0b0c0d0e0f, "R4");
        idle(14);
        chk("R4", "scoreboard drained", 128'(exp_q.size()), 128'h0);

        done = 1'b1;
        $display("%0d/%0d checks passed", n_total - n_fail, n_total);
        $finish;
    end

    initial begin
        #(200000 * 10);
        if (!done) begin
            n_total++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_total - n_fail, n_total);
            $finish;
        end
    end

endmodule